// File: doc/BRIEF.md
# Inter-Processor Message Dispatcher

This unit sits on the receiving processor. The interrupt entry routine fetches a 64-bit inter-processor message and hands it to the unit. The unit splits the message into an 8-bit command code and a 56-bit argument. It classifies the code into one of several fixed ranges: translation-buffer invalidation, cache maintenance, barriers, synchronisation, system control and user-defined. It then raises exactly one single-cycle request toward the local resource that carries out the work. The translation buffers, caches and store buffer are outside the unit and are reached only through request and status pins.

A full barrier is handled differently from every other command. The unit asks the store buffer to drain and then stays busy until the buffer reports that it is empty. Only then does it return an acknowledge toward the sending processor. For every other valid command the acknowledge is optional: the sender selects it per message with a flag that comes with the message. A code outside the defined set raises a one-cycle error flag and has no side effect. While the unit is working on a message it holds its ready output low, so the interrupt routine cannot hand it a second one.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, `msg_ready` is high and every request output, `ack_out` and `cmd_err` are low.
- R2: A message is taken only on a clock edge where `msg_valid` and `msg_ready` are both high. `msg_ready` is low from the next cycle until the message has been fully handled. A valid message offered while `msg_ready` is low produces no request.
- R3: The command is bits [63:56] of `msg_data` and the argument is bits [55:0]. From the cycle after acceptance until the next acceptance, `op_param` holds the argument, `op_asn` holds argument bits [55:48] and `op_va` holds argument bits [47:0].
- R4: Translation-buffer codes: 0x01 pulses `tlb_flush_all`, 0x02 pulses `tlb_flush_asn`, 0x03 pulses both `itlb_flush_va` and `dtlb_flush_va`, 0x04 pulses only `itlb_flush_va`, and 0x05 pulses only `dtlb_flush_va`.
- R5: Cache codes 0x10, 0x11, 0x12 and 0x13 pulse `cache_req`, with `cache_op` equal to 0 (invalidate line), 1 (flush line), 2 (evict line) or 3 (invalidate all) respectively.
- R6: Code 0x20 (full barrier) pulses `wb_drain_req`. The unit then keeps `msg_ready` and `ack_out` low until `wb_drained` is sampled high, and pulses `ack_out` in the following cycle, whatever the acknowledge flag says.
- R7: Code 0x21 (write barrier) pulses `wb_drain_req` and does not wait for `wb_drained`.
- R8: Code 0x30 pulses `sync_req` and code 0x31 pulses `sync_done`.
- R9: Code 0x40 pulses `halt_req`, 0x41 pulses `wake_req` and 0x42 pulses `ctx_switch_req`.
- R10: Codes 0xF0 to 0xFF pulse `custom_req`, with `custom_id` equal to the low four bits of the code.
- R11: For every valid code other than 0x20, `ack_out` pulses in the cycle right after the request pulse if `msg_ack_req` was high at acceptance. Otherwise `ack_out` stays low.
- R12: Any other code (for example 0x00, 0x06, 0x22, 0x50) pulses `cmd_err` in the request slot. It drives no request output and never pulses `ack_out`, even when `msg_ack_req` is high.
- R13: The request (or `cmd_err`) pulse lasts one cycle and falls in the second cycle after the accepting edge. At most one request kind is active in any cycle. `tlb va` both counts as one kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Interrupt routine offers a message |
| msg_data | input | 64 | Message: code in [63:56], argument in [55:0] |
| msg_ack_req | input | 1 | Sender wants an acknowledge for this message |
| msg_ready | output | 1 | Unit can take a message |
| tlb_flush_all | output | 1 | Invalidate all translation entries |
| tlb_flush_asn | output | 1 | Invalidate entries of one address-space number |
| itlb_flush_va | output | 1 | Invalidate one address in the instruction buffer |
| dtlb_flush_va | output | 1 | Invalidate one address in the data buffer |
| cache_req | output | 1 | Cache maintenance request |
| cache_op | output | 2 | Cache operation kind |
| wb_drain_req | output | 1 | Ask the store buffer to drain |
| wb_drained | input | 1 | Store buffer is empty |
| sync_req | output | 1 | Synchronisation request received |
| sync_done | output | 1 | Synchronisation acknowledge received |
| halt_req | output | 1 | Halt this processor |
| wake_req | output | 1 | Wake this processor |
| ctx_switch_req | output | 1 | Context switch request |
| custom_req | output | 1 | User-defined command |
| custom_id | output | 4 | Low nibble of a user-defined code |
| op_param | output | 56 | Argument of the current message |
| op_asn | output | 8 | Address-space number field of the argument |
| op_va | output | 48 | Address field of the argument |
| ack_out | output | 1 | Acknowledge toward the sending processor |
| cmd_err | output | 1 | Unknown command code |

## Verification
The assertions assume that `wb_drained` is a level that only matters while a full barrier waits. They also assume that `msg_data` and `msg_ack_req` need only be valid in the cycle where they are accepted. The bench drives every input half a cycle away from the active edge. It raises `msg_valid` for one cycle only when `msg_ready` is high, except in the scenario that deliberately offers a message while the unit is busy. It raises `wb_drained` only during a barrier wait, and drops it again after the acknowledge.

// File: rtl/ipi_dispatch_pkg.sv
package ipi_dispatch_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_ISSUE, ST_WAIT_DRAIN, ST_ACK
  } seq_state_e;

  typedef enum logic [4:0] {
    OP_BAD, OP_TLB_ALL, OP_TLB_ASN, OP_TLB_VA_BOTH, OP_TLB_VA_I, OP_TLB_VA_D,
    OP_C_INV_LINE, OP_C_FLUSH_LINE, OP_C_EVICT_LINE, OP_C_INV_ALL,
    OP_MB_FULL, OP_MB_WRITE, OP_SYNC_REQ, OP_SYNC_DONE,
    OP_HALT, OP_WAKE, OP_CTX, OP_CUSTOM
  } op_kind_e;

  localparam logic [CMD_W-1:0] C_TLB_ALL    = 8'h01;
  localparam logic [CMD_W-1:0] C_TLB_ASN    = 8'h02;
  localparam logic [CMD_W-1:0] C_TLB_VA_BOT = 8'h03;
  localparam logic [CMD_W-1:0] C_TLB_VA_I   = 8'h04;
  localparam logic [CMD_W-1:0] C_TLB_VA_D   = 8'h05;
  localparam logic [CMD_W-1:0] C_CACHE_BASE = 8'h10;
  localparam logic [CMD_W-1:0] C_MB_FULL    = 8'h20;
  localparam logic [CMD_W-1:0] C_MB_WRITE   = 8'h21;
  localparam logic [CMD_W-1:0] C_SYNC_REQ   = 8'h30;
  localparam logic [CMD_W-1:0] C_SYNC_DONE  = 8'h31;
  localparam logic [CMD_W-1:0] C_HALT       = 8'h40;
  localparam logic [CMD_W-1:0] C_WAKE       = 8'h41;
  localparam logic [CMD_W-1:0] C_CTX        = 8'h42;
  localparam logic [3:0]       C_CUSTOM_HI  = 4'hF;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_dispatch_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output op_kind_e         op
);

  always_comb begin
    op = OP_BAD;
    if (cmd[CMD_W-1 -: 4] == C_CUSTOM_HI) begin
      op = OP_CUSTOM;
    end else begin
      case (cmd)
        C_TLB_ALL:          op = OP_TLB_ALL;
        C_TLB_ASN:          op = OP_TLB_ASN;
        C_TLB_VA_BOT:       op = OP_TLB_VA_BOTH;
        C_TLB_VA_I:         op = OP_TLB_VA_I;
        C_TLB_VA_D:         op = OP_TLB_VA_D;
        C_CACHE_BASE:       op = OP_C_INV_LINE;
        C_CACHE_BASE + 8'd1: op = OP_C_FLUSH_LINE;
        C_CACHE_BASE + 8'd2: op = OP_C_EVICT_LINE;
        C_CACHE_BASE + 8'd3: op = OP_C_INV_ALL;
        C_MB_FULL:          op = OP_MB_FULL;
        C_MB_WRITE:         op = OP_MB_WRITE;
        C_SYNC_REQ:         op = OP_SYNC_REQ;
        C_SYNC_DONE:        op = OP_SYNC_DONE;
        C_HALT:             op = OP_HALT;
        C_WAKE:             op = OP_WAKE;
        C_CTX:              op = OP_CTX;
        default:            op = OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/ipi_seq_fsm.sv
module ipi_seq_fsm
  import ipi_dispatch_pkg::*;
#(
  parameter int MSG_W   = 64,
  localparam int PARAM_W = MSG_W - CMD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [MSG_W-1:0]   msg_data,
  input  logic               msg_ack_req,
  input  logic               wb_drained,
  input  op_kind_e           dec_op,
  output logic               msg_ready,
  output seq_state_e         state,
  output op_kind_e           op_q,
  output logic [CMD_W-1:0]   cmd_q,
  output logic [PARAM_W-1:0] param_q
);

  seq_state_e state_d;
  logic       ack_q;
  logic       cap_en;
  logic       op_en;

  assign msg_ready = (state == ST_IDLE);
  assign cap_en    = msg_ready && msg_valid;
  assign op_en     = (state == ST_DECODE);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:   if (msg_valid) state_d = ST_DECODE;
      ST_DECODE: state_d = ST_ISSUE;
      ST_ISSUE: begin
        if (op_q == OP_MB_FULL)                 state_d = ST_WAIT_DRAIN;
        else if (op_q != OP_BAD && ack_q)       state_d = ST_ACK;
        else                                    state_d = ST_IDLE;
      end
      ST_WAIT_DRAIN: if (wb_drained) state_d = ST_ACK;
      ST_ACK:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      param_q <= '0;
      ack_q   <= 1'b0;
    end else if (cap_en) begin
      cmd_q   <= msg_data[MSG_W-1 -: CMD_W];
      param_q <= msg_data[PARAM_W-1:0];
      ack_q   <= msg_ack_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= OP_BAD;
    else if (op_en) op_q <= dec_op;
  end

endmodule

// File: rtl/ipi_req_drive.sv
module ipi_req_drive
  import ipi_dispatch_pkg::*;
(
  input  seq_state_e       state,
  input  op_kind_e         op_q,
  input  logic [CMD_W-1:0] cmd_q,
  output logic             tlb_flush_all,
  output logic             tlb_flush_asn,
  output logic             itlb_flush_va,
  output logic             dtlb_flush_va,
  output logic             cache_req,
  output logic [1:0]       cache_op,
  output logic             wb_drain_req,
  output logic             sync_req,
  output logic             sync_done,
  output logic             halt_req,
  output logic             wake_req,
  output logic             ctx_switch_req,
  output logic             custom_req,
  output logic [3:0]       custom_id,
  output logic             ack_out,
  output logic             cmd_err
);

  logic slot;
  assign slot = (state == ST_ISSUE);

  always_comb begin
    tlb_flush_all  = slot && (op_q == OP_TLB_ALL);
    tlb_flush_asn  = slot && (op_q == OP_TLB_ASN);
    itlb_flush_va  = slot && (op_q == OP_TLB_VA_BOTH || op_q == OP_TLB_VA_I);
    dtlb_flush_va  = slot && (op_q == OP_TLB_VA_BOTH || op_q == OP_TLB_VA_D);
    cache_req      = slot && (op_q == OP_C_INV_LINE || op_q == OP_C_FLUSH_LINE ||
                              op_q == OP_C_EVICT_LINE || op_q == OP_C_INV_ALL);
    wb_drain_req   = slot && (op_q == OP_MB_FULL || op_q == OP_MB_WRITE);
    sync_req       = slot && (op_q == OP_SYNC_REQ);
    sync_done      = slot && (op_q == OP_SYNC_DONE);
    halt_req       = slot && (op_q == OP_HALT);
    wake_req       = slot && (op_q == OP_WAKE);
    ctx_switch_req = slot && (op_q == OP_CTX);
    custom_req     = slot && (op_q == OP_CUSTOM);
    cmd_err        = slot && (op_q == OP_BAD);
    ack_out        = (state == ST_ACK);
  end

  always_comb begin
    case (op_q)
      OP_C_FLUSH_LINE: cache_op = 2'd1;
      OP_C_EVICT_LINE: cache_op = 2'd2;
      OP_C_INV_ALL:    cache_op = 2'd3;
      default:         cache_op = 2'd0;
    endcase
  end

  assign custom_id = cmd_q[3:0];

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_dispatch_pkg::*;
#(
  parameter int MSG_W   = 64,
  parameter int ASN_W   = 8,
  localparam int PARAM_W = MSG_W - CMD_W,
  localparam int VA_W    = PARAM_W - ASN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [MSG_W-1:0]   msg_data,
  input  logic               msg_ack_req,
  output logic               msg_ready,
  output logic               tlb_flush_all,
  output logic               tlb_flush_asn,
  output logic               itlb_flush_va,
  output logic               dtlb_flush_va,
  output logic               cache_req,
  output logic [1:0]         cache_op,
  output logic               wb_drain_req,
  input  logic               wb_drained,
  output logic               sync_req,
  output logic               sync_done,
  output logic               halt_req,
  output logic               wake_req,
  output logic               ctx_switch_req,
  output logic               custom_req,
  output logic [3:0]         custom_id,
  output logic [PARAM_W-1:0] op_param,
  output logic [ASN_W-1:0]   op_asn,
  output logic [VA_W-1:0]    op_va,
  output logic               ack_out,
  output logic               cmd_err
);

  seq_state_e       seq_state;
  op_kind_e         dec_op;
  op_kind_e         op_q;
  logic [CMD_W-1:0] cmd_q;

  ipi_seq_fsm #(.MSG_W(MSG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_data   (msg_data),
    .msg_ack_req(msg_ack_req),
    .wb_drained (wb_drained),
    .dec_op     (dec_op),
    .msg_ready  (msg_ready),
    .state      (seq_state),
    .op_q       (op_q),
    .cmd_q      (cmd_q),
    .param_q    (op_param)
  );

  ipi_cmd_decode u_dec (
    .cmd(cmd_q),
    .op (dec_op)
  );

  ipi_req_drive u_drv (
    .state         (seq_state),
    .op_q          (op_q),
    .cmd_q         (cmd_q),
    .tlb_flush_all (tlb_flush_all),
    .tlb_flush_asn (tlb_flush_asn),
    .itlb_flush_va (itlb_flush_va),
    .dtlb_flush_va (dtlb_flush_va),
    .cache_req     (cache_req),
    .cache_op      (cache_op),
    .wb_drain_req  (wb_drain_req),
    .sync_req      (sync_req),
    .sync_done     (sync_done),
    .halt_req      (halt_req),
    .wake_req      (wake_req),
    .ctx_switch_req(ctx_switch_req),
    .custom_req    (custom_req),
    .custom_id     (custom_id),
    .ack_out       (ack_out),
    .cmd_err       (cmd_err)
  );

  assign op_asn = op_param[PARAM_W-1 -: ASN_W];
  assign op_va  = op_param[VA_W-1:0];

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk
  import ipi_dispatch_pkg::*;
#(
  parameter int PARAM_W = 56
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic               wb_drained,
  input seq_state_e         seq_state,
  input logic [PARAM_W-1:0] op_param,
  input logic [12:0]        kinds,
  input logic               ack_out
);

  logic any_kind;
  assign any_kind = |kinds;

  // R2: busy right after taking a message
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_ready);

  // R3: argument held while busy
  a_r3_param_held: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ready |=> $stable(op_param));

  // R13: at most one request kind per cycle
  a_r13_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kinds));

  // R13: request pulses last a single cycle
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    any_kind |=> !any_kind);

  // R12: an error is never followed by an acknowledge
  a_r12_err_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    kinds[0] |=> !ack_out);

  // R6: barrier wait persists until drained
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_WAIT_DRAIN) && !wb_drained |=>
      (seq_state == ST_WAIT_DRAIN) && !ack_out && !msg_ready);

  // R6: drained during wait gives an acknowledge next
  a_r6_ack_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_WAIT_DRAIN) && wb_drained |=> ack_out);

  // R1: ready and acknowledge never overlap
  a_r1_ack_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> !msg_ready);

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.PARAM_W(PARAM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .wb_drained(wb_drained),
  .seq_state (seq_state),
  .op_param  (op_param),
  .kinds     ({tlb_flush_all, tlb_flush_asn, itlb_flush_va || dtlb_flush_va,
               cache_req, wb_drain_req, sync_req, sync_done, halt_req,
               wake_req, ctx_switch_req, custom_req, 1'b0, cmd_err}),
  .ack_out   (ack_out)
);

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;

  logic        clk;
  logic        rst_n;
  logic        msg_valid;
  logic [63:0] msg_data;
  logic        msg_ack_req;
  logic        msg_ready;
  logic        tlb_flush_all, tlb_flush_asn, itlb_flush_va, dtlb_flush_va;
  logic        cache_req;
  logic [1:0]  cache_op;
  logic        wb_drain_req, wb_drained;
  logic        sync_req, sync_done, halt_req, wake_req, ctx_switch_req;
  logic        custom_req;
  logic [3:0]  custom_id;
  logic [55:0] op_param;
  logic [7:0]  op_asn;
  logic [47:0] op_va;
  logic        ack_out, cmd_err;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  ipi_dispatch i_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_ack_req(msg_ack_req), .msg_ready(msg_ready),
    .tlb_flush_all(tlb_flush_all), .tlb_flush_asn(tlb_flush_asn),
    .itlb_flush_va(itlb_flush_va), .dtlb_flush_va(dtlb_flush_va),
    .cache_req(cache_req), .cache_op(cache_op),
    .wb_drain_req(wb_drain_req), .wb_drained(wb_drained),
    .sync_req(sync_req), .sync_done(sync_done), .halt_req(halt_req),
    .wake_req(wake_req), .ctx_switch_req(ctx_switch_req),
    .custom_req(custom_req), .custom_id(custom_id),
    .op_param(op_param), .op_asn(op_asn), .op_va(op_va),
    .ack_out(ack_out), .cmd_err(cmd_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bit order: tlb_all tlb_asn itlb dtlb cache drain sreq sdone halt wake ctx custom err
  function automatic logic [12:0] pulses();
    return {tlb_flush_all, tlb_flush_asn, itlb_flush_va, dtlb_flush_va,
            cache_req, wb_drain_req, sync_req, sync_done, halt_req,
            wake_req, ctx_switch_req, custom_req, cmd_err};
  endfunction

  function automatic logic [12:0] expect_pulses(input logic [7:0] c);
    if (c[7:4] == 4'hF) return 13'b0000000000010;
    case (c)
      8'h01: return 13'b1000000000000;
      8'h02: return 13'b0100000000000;
      8'h03: return 13'b0011000000000;
      8'h04: return 13'b0010000000000;
      8'h05: return 13'b0001000000000;
      8'h10, 8'h11, 8'h12, 8'h13: return 13'b0000100000000;
      8'h20, 8'h21: return 13'b0000010000000;
      8'h30: return 13'b0000001000000;
      8'h31: return 13'b0000000100000;
      8'h40: return 13'b0000000010000;
      8'h41: return 13'b0000000001000;
      8'h42: return 13'b0000000000100;
      default: return 13'b0000000000001;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // offer one message, return after the issue slot has been sampled
  task automatic offer(input logic [7:0] c, input logic [55:0] p, input logic want);
    @(negedge clk);
    msg_valid = 1'b1; msg_data = {c, p}; msg_ack_req = want;
    @(negedge clk);
    msg_valid = 1'b0; msg_data = '0; msg_ack_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cmd(input string req, input logic [7:0] c, input logic [55:0] p,
                         input logic want);
    logic [12:0] exp;
    logic        bad;
    exp = expect_pulses(c);
    bad = exp[0];
    offer(c, p, want);
    check({req, " request pulse"}, 64'(pulses()), 64'(exp));
    check("R13 issue slot busy", 64'(msg_ready), 64'd0);
    check("R3 argument", 64'(op_param), 64'(p));
    if (c[7:4] == 4'h1) check("R5 cache_op", 64'(cache_op), 64'(c[1:0]));
    if (c[7:4] == 4'hF) check("R10 custom_id", 64'(custom_id), 64'(c[3:0]));
    @(negedge clk);
    check("R13 pulse width", 64'(pulses()), 64'd0);
    check(bad ? "R12 no ack" : "R11 ack", 64'(ack_out), 64'(want && !bad));
    if (want && !bad) @(negedge clk);
    check("R2 ready again", 64'(msg_ready), 64'd1);
  endtask

  task automatic t_reset();
    check("R1 ready", 64'(msg_ready), 64'd1);
    check("R1 quiet", 64'({pulses(), ack_out}), 64'd0);
  endtask

  task automatic t_tlb();
    run_cmd("R4 all", 8'h01, 56'h0, 1'b0);
    run_cmd("R4 asn", 8'h02, 56'h3C_0000_0000_0000, 1'b1);
    run_cmd("R4 va both", 8'h03, 56'h11_2222_3333_4444, 1'b0);
    check("R3 asn field", 64'(op_asn), 64'h11);
    check("R3 va field", 64'(op_va), 64'h2222_3333_4444);
    run_cmd("R4 va itb", 8'h04, 56'hA5_0000_DEAD_B000, 1'b1);
    check("R3 asn field", 64'(op_asn), 64'hA5);
    run_cmd("R4 va dtb", 8'h05, 56'h07_FFFF_0000_1000, 1'b0);
    check("R3 va field", 64'(op_va), 64'hFFFF_0000_1000);
  endtask

  task automatic t_cache();
    for (int i = 0; i < 4; i++)
      run_cmd("R5 cache", 8'h10 + 8'(i), 56'h40 * 56'(i + 1), i[0]);
  endtask

  task automatic t_misc();
    run_cmd("R7 write barrier", 8'h21, 56'h0, 1'b1);
    run_cmd("R7 write barrier", 8'h21, 56'h0, 1'b0);
    run_cmd("R8 sync req", 8'h30, 56'h5, 1'b1);
    run_cmd("R8 sync done", 8'h31, 56'h6, 1'b0);
    run_cmd("R9 halt", 8'h40, 56'h0, 1'b0);
    run_cmd("R9 wake", 8'h41, 56'h1, 1'b1);
    run_cmd("R9 ctx", 8'h42, 56'hABCDEF, 1'b0);
    run_cmd("R10 custom", 8'hF0, 56'h12, 1'b0);
    run_cmd("R10 custom", 8'hFB, 56'h34, 1'b1);
  endtask

  task automatic t_unknown();
    run_cmd("R12 unknown", 8'h00, 56'h1, 1'b1);
    run_cmd("R12 unknown", 8'h06, 56'h2, 1'b1);
    run_cmd("R12 unknown", 8'h22, 56'h3, 1'b1);
    run_cmd("R12 unknown", 8'h50, 56'h4, 1'b0);
  endtask

  task automatic t_full_barrier(input logic want);
    offer(8'h20, 56'h0, want);
    check("R6 drain pulse", 64'(pulses()), 64'(13'b0000010000000));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R6 waits ack", 64'(ack_out), 64'd0);
      check("R6 waits busy", 64'(msg_ready), 64'd0);
      check("R6 no second drain", 64'(wb_drain_req), 64'd0);
    end
    wb_drained = 1'b1;
    @(negedge clk);
    wb_drained = 1'b0;
    check("R6 ack after drain", 64'(ack_out), 64'd1);
    @(negedge clk);
    check("R6 single ack", 64'(ack_out), 64'd0);
    check("R6 ready after ack", 64'(msg_ready), 64'd1);
  endtask

  task automatic t_busy_ignored();
    logic [12:0] seen;
    seen = '0;
    @(negedge clk);
    msg_valid = 1'b1; msg_data = {8'h41, 56'h0}; msg_ack_req = 1'b1;
    @(negedge clk);
    msg_data = {8'h40, 56'h9};
    @(negedge clk);
    seen = pulses();
    check("R2 first taken", 64'(seen), 64'(13'b0000000001000));
    @(negedge clk);
    msg_valid = 1'b0; msg_data = '0; msg_ack_req = 1'b0;
    check("R2 busy", 64'(ack_out), 64'd1);
    check("R2 ignored arg", 64'(op_param), 64'd0);
    seen = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen = seen | pulses();
    end
    check("R2 busy offer ignored", 64'(seen), 64'd0);
  endtask

  initial begin
    msg_valid = 1'b0; msg_data = '0; msg_ack_req = 1'b0; wb_drained = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tlb();
    t_cache();
    t_full_barrier(1'b0);
    t_full_barrier(1'b1);
    t_misc();
    t_unknown();
    t_busy_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

endmodule